// File: doc/BRIEF.md
# Register-Triggered Line Copy Engine

This block is a small set of memory-mapped registers that moves one 32-byte line between physical addresses by way of four 64-bit staging registers. Software writes a source address to start a fetch: the engine reads four consecutive doublewords from memory into the staging registers. Software then writes a destination address to start a store: the engine writes the four staging registers back out to four consecutive doublewords. The staging registers can also be loaded directly from the register bus. A write to an address register is the command itself, so no separate go bit exists.

The CPU side is a single-cycle register bus that makes 8-byte or 4-byte accesses. An access completes on a clock edge where `req_i` and `ready_o` are both high. The engine also holds a control register, an error register and a port-address register. The port-address register comes out of reset with a value derived from the `cpu_id_i` strap. The memory side is a 64-bit master port. Each transfer holds its request until the memory answers with an acknowledge or an error.

Top module: `line_xfer_engine`

## Requirements
- R1: After reset the port-address register (offset 0xF00) reads `((cpu_id_i + 8) mod 16) << 24`, the control and error registers read zero, `ready_o` is high and `mem_req_o` is low.
- R2: An 8-byte write to offset 0x100 starts four memory reads (`mem_we_o`=0) at base, base+8, base+16 and base+24, in that order. The read data fill staging registers 0, 1, 2 and 3 in order.
- R3: An 8-byte write to offset 0x200 starts four memory writes (`mem_we_o`=1) at base, base+8, base+16 and base+24, in that order. The write data are staging registers 0 to 3.
- R4: An 8-byte write to offset 0x000, 0x008, 0x010 or 0x018 loads staging register 0, 1, 2 or 3 with `{wdata_hi_i, wdata_lo_i}`.
- R5: The control register at 0xA00 supports 8-byte reads and writes. A 4-byte write at 0xA04 replaces only bits 31:0 from `wdata_lo_i`. A 4-byte read at 0xA04 returns bits 31:0 on `rdata_lo_o` and zero on `rdata_hi_o`.
- R6: While `mem_req_o` is high and no acknowledge or error has arrived, the request, address, direction and write data stay unchanged on the next cycle.
- R7: `ready_o` goes low on the cycle after a trigger write and stays low until the fourth transfer is acknowledged or the burst aborts. No register access is accepted meanwhile.
- R8: An error response (`mem_err_i` with `mem_req_o`) ends the burst at once, leaves the staging register of that beat and of later beats unchanged, and sets bit 0 of the error register. The error register at 0xE00 is written and read with 8-byte accesses.
- R9: The port-address register at 0xF00 supports 8-byte writes and reads.
- R10: An access of the wrong size, or to an unmapped offset, changes no state, starts no transfer and reads as zero. Examples: a 4-byte access to 0xA00 or 0x100, a 4-byte write to a staging register, an 8-byte read of 0xA04, a read of a staging register, any access to 0x300.
- R11: Only bits 31:0 of a source or destination write (`wdata_lo_i`) form the base address. `wdata_hi_i` has no effect on `mem_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_id_i | input | 4 | Processor index strap for the port-address reset value |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| size8_i | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| addr_i | input | 12 | Byte offset within the register block |
| wdata_hi_i | input | 32 | Write data bits 63:32 |
| wdata_lo_i | input | 32 | Write data bits 31:0 (whole datum of a 4-byte write) |
| ready_o | output | 1 | Engine idle; access completes when high with req_i |
| rdata_hi_o | output | 32 | Read data bits 63:32, same cycle as the read |
| rdata_lo_o | output | 32 | Read data bits 31:0 |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | Memory transfer direction, 1 = write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 64 | Memory write data |
| mem_rdata_i | input | 64 | Memory read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Transfer completed |
| mem_err_i | input | 1 | Transfer failed |

## Verification
A wrong beat counter or base register in the engine shows up at once on `mem_addr_o`: the address of the very next beat is wrong, and the scoreboard catches it on the acknowledge of that beat. Staging corruption stays hidden until a later store burst drives the staging registers onto `mem_wdata_o`, so each fetch is followed by a store that exposes what was captured. The burst after an error response is checked the same way. A stuck busy state shows as `ready_o` staying low, which stalls the next access and trips the watchdog. A mis-decoded offset or size shows as a changed readback or as a memory request that should not have been issued.

// File: rtl/lxe_pkg.sv
package lxe_pkg;
  localparam int PA_W = 32;

  localparam logic [11:0] OFF_SRC     = 12'h100;
  localparam logic [11:0] OFF_DST     = 12'h200;
  localparam logic [11:0] OFF_CTRL    = 12'hA00;
  localparam logic [11:0] OFF_CTRL_LO = 12'hA04;
  localparam logic [11:0] OFF_ERR     = 12'hE00;
  localparam logic [11:0] OFF_PORT    = 12'hF00;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/lxe_regs.sv
module lxe_regs
  import lxe_pkg::*;
#(
  parameter int DW         = 64,
  parameter int LINE_BEATS = 4,
  parameter int OFF_W      = 12,
  parameter int CPU_W      = 4,
  parameter int IDX_W      = $clog2(LINE_BEATS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CPU_W-1:0]         cpu_id_i,
  input  logic                     acc_i,
  input  logic                     we_i,
  input  logic                     size8_i,
  input  logic [OFF_W-1:0]         addr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     fill_we_i,
  input  logic [IDX_W-1:0]         fill_idx_i,
  input  logic [DW-1:0]            fill_data_i,
  input  logic                     err_set_i,
  output logic [DW-1:0]            rdata_o,
  output logic [LINE_BEATS*DW-1:0] stage_o,
  output logic                     start_fetch_o,
  output logic                     start_store_o
);
  localparam int HALF     = DW / 2;
  localparam int STG_SPAN = LINE_BEATS * 8;

  logic [DW-1:0] ctrl_q, err_q, port_q, port_rst;
  logic [3:0]    port_node;
  logic          wr8, wr4, stg_hit;
  logic [IDX_W-1:0] stg_idx;

  assign wr8 = acc_i & we_i & size8_i;
  assign wr4 = acc_i & we_i & ~size8_i;
  assign stg_hit = (addr_i < OFF_W'(STG_SPAN)) && (addr_i[2:0] == 3'b000);
  assign stg_idx = addr_i[IDX_W+2:3];

  assign start_fetch_o = wr8 && (addr_i == OFF_SRC);
  assign start_store_o = wr8 && (addr_i == OFF_DST);

  // port node = (cpu + 8) mod 16, placed at bit 24
  assign port_node = 4'(cpu_id_i) + 4'd8;
  assign port_rst  = DW'({port_node, 24'h000000});

  for (genvar g = 0; g < LINE_BEATS; g++) begin : g_stage
    logic [DW-1:0] stage_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
      end else if (wr8 && stg_hit && (stg_idx == IDX_W'(g))) begin
        stage_q <= wdata_i;
      end else if (fill_we_i && (fill_idx_i == IDX_W'(g))) begin
        stage_q <= fill_data_i;
      end
    end
    assign stage_o[g*DW +: DW] = stage_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr8 && addr_i == OFF_CTRL) begin
      ctrl_q <= wdata_i;
    end else if (wr4 && addr_i == OFF_CTRL_LO) begin
      ctrl_q[HALF-1:0] <= wdata_i[HALF-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
    end else if (wr8 && addr_i == OFF_ERR) begin
      err_q <= wdata_i;
    end else if (err_set_i) begin
      err_q[0] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q <= port_rst;
    end else if (wr8 && addr_i == OFF_PORT) begin
      port_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!size8_i) begin
      if (addr_i == OFF_CTRL_LO) rdata_o = DW'(ctrl_q[HALF-1:0]);
    end else begin
      unique case (addr_i)
        OFF_CTRL: rdata_o = ctrl_q;
        OFF_ERR:  rdata_o = err_q;
        OFF_PORT: rdata_o = port_q;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/lxe_burst.sv
module lxe_burst
  import lxe_pkg::*;
#(
  parameter int DW         = 64,
  parameter int LINE_BEATS = 4,
  parameter int IDX_W      = $clog2(LINE_BEATS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_fetch_i,
  input  logic                     start_store_i,
  input  logic [PA_W-1:0]          base_i,
  input  logic [LINE_BEATS*DW-1:0] stage_i,
  input  logic                     mem_ack_i,
  input  logic                     mem_err_i,
  input  logic [DW-1:0]            mem_rdata_i,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [PA_W-1:0]          mem_addr_o,
  output logic [DW-1:0]            mem_wdata_o,
  output logic                     fill_we_o,
  output logic [IDX_W-1:0]         fill_idx_o,
  output logic [DW-1:0]            fill_data_o,
  output logic                     err_set_o,
  output logic                     busy_o
);
  localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(LINE_BEATS - 1);

  xfer_state_e      state_q;
  logic [IDX_W-1:0] beat_q;
  logic [PA_W-1:0]  base_q;
  logic             beat_done, last;

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = busy_o;
  assign mem_we_o    = (state_q == ST_STORE);
  assign mem_addr_o  = base_q + PA_W'({beat_q, 3'b000});
  assign mem_wdata_o = stage_i[beat_q*DW +: DW];
  assign last        = (beat_q == LAST_BEAT);
  assign beat_done   = mem_req_o && mem_ack_i && !mem_err_i;

  assign fill_we_o   = beat_done && (state_q == ST_FETCH);
  assign fill_idx_o  = beat_q;
  assign fill_data_o = mem_rdata_i;
  assign err_set_o   = mem_req_o && mem_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      base_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          beat_q <= '0;
          if (start_fetch_i) begin
            state_q <= ST_FETCH;
            base_q  <= base_i;
          end else if (start_store_i) begin
            state_q <= ST_STORE;
            base_q  <= base_i;
          end
        end
        default: begin
          if (err_set_o) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
          end else if (beat_done) begin
            if (last) begin
              state_q <= ST_IDLE;
              beat_q  <= '0;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/line_xfer_engine.sv
module line_xfer_engine
  import lxe_pkg::*;
#(
  parameter int LINE_BEATS = 4,
  parameter int OFF_W      = 12,
  parameter int CPU_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CPU_W-1:0] cpu_id_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             size8_i,
  input  logic [OFF_W-1:0] addr_i,
  input  logic [31:0]      wdata_hi_i,
  input  logic [31:0]      wdata_lo_i,
  output logic             ready_o,
  output logic [31:0]      rdata_hi_o,
  output logic [31:0]      rdata_lo_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [63:0]      mem_wdata_o,
  input  logic [63:0]      mem_rdata_i,
  input  logic             mem_ack_i,
  input  logic             mem_err_i
);
  localparam int DW    = 64;
  localparam int IDX_W = $clog2(LINE_BEATS);

  logic                     acc, busy;
  logic [DW-1:0]            wdata, rdata;
  logic [LINE_BEATS*DW-1:0] stage;
  logic                     start_fetch, start_store, fill_we, err_set;
  logic [IDX_W-1:0]         fill_idx;
  logic [DW-1:0]            fill_data;

  assign ready_o = ~busy;
  assign acc     = req_i & ready_o;
  assign wdata   = {wdata_hi_i, wdata_lo_i};
  assign {rdata_hi_o, rdata_lo_o} = (acc && !we_i) ? rdata : '0;

  lxe_regs #(
    .DW(DW), .LINE_BEATS(LINE_BEATS), .OFF_W(OFF_W), .CPU_W(CPU_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk_i, .rst_ni, .cpu_id_i,
    .acc_i(acc), .we_i, .size8_i, .addr_i, .wdata_i(wdata),
    .fill_we_i(fill_we), .fill_idx_i(fill_idx), .fill_data_i(fill_data),
    .err_set_i(err_set), .rdata_o(rdata), .stage_o(stage),
    .start_fetch_o(start_fetch), .start_store_o(start_store)
  );

  lxe_burst #(
    .DW(DW), .LINE_BEATS(LINE_BEATS), .IDX_W(IDX_W)
  ) u_burst (
    .clk_i, .rst_ni,
    .start_fetch_i(start_fetch), .start_store_i(start_store),
    .base_i(wdata_lo_i), .stage_i(stage),
    .mem_ack_i, .mem_err_i, .mem_rdata_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .fill_we_o(fill_we), .fill_idx_o(fill_idx), .fill_data_o(fill_data),
    .err_set_o(err_set), .busy_o(busy)
  );
endmodule

// File: rtl/lxe_checker.sv
module lxe_checker
  import lxe_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic             size8_i,
  input logic [OFF_W-1:0] addr_i,
  input logic             ready_o,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [31:0]      mem_addr_o,
  input logic [63:0]      mem_wdata_o,
  input logic             mem_ack_i,
  input logic             mem_err_i
);
  logic acc8w;
  assign acc8w = req_i && ready_o && we_i && size8_i;

  a_r1_idle_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> ready_o && !mem_req_o);

  a_r2_fetch_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc8w && addr_i == OFF_SRC |=> mem_req_o && !mem_we_o);

  a_r3_store_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc8w && addr_i == OFF_DST |=> mem_req_o && mem_we_o);

  a_r6_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !mem_err_i |=>
      mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r7_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o);

  a_r8_err_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_err_i |=> !mem_req_o);

  a_r10_short_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ready_o && !size8_i && (addr_i == OFF_SRC || addr_i == OFF_DST) |=> !mem_req_o);
endmodule

bind line_xfer_engine lxe_checker #(.OFF_W(OFF_W)) u_lxe_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .size8_i(size8_i),
  .addr_i(addr_i), .ready_o(ready_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .mem_err_i(mem_err_i)
);

// File: tb/line_xfer_engine_bench.sv
module line_xfer_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cpu_id = 4'd5;
  logic        req = 1'b0, we = 1'b0, size8 = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdh = '0, wdl = '0;
  logic        ready;
  logic [31:0] rdh, rdl;
  logic        mreq, mwe;
  logic [31:0] maddr;
  logic [63:0] mwdata;
  logic [63:0] mrdata = '0;
  logic        mack = 1'b0, merr = 1'b0;

  int n_run = 0, n_fail = 0;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [63:0] data;
    string       tag;
  } item_t;
  item_t exp_q[$];

  int          lat = 0;
  int          wait_cnt = 0;
  logic [31:0] err_addr = 32'hFFFF_FFF8;

  always #4 clk = ~clk;

  line_xfer_engine u_line_xfer_engine (
    .clk_i(clk), .rst_ni(rst_n), .cpu_id_i(cpu_id),
    .req_i(req), .we_i(we), .size8_i(size8), .addr_i(addr),
    .wdata_hi_i(wdh), .wdata_lo_i(wdl), .ready_o(ready),
    .rdata_hi_o(rdh), .rdata_lo_o(rdl),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata), .mem_ack_i(mack), .mem_err_i(merr)
  );

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {a ^ 32'hA5A5_0000, ~a};
  endfunction

  task automatic check(input bit ok, input string req_tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic push(input logic w, input logic [31:0] a, input logic [63:0] d,
                      input string t);
    item_t it;
    it.we = w; it.addr = a; it.data = d; it.tag = t;
    exp_q.push_back(it);
  endtask

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    automatic bit was = mack | merr;
    mack = 1'b0;
    merr = 1'b0;
    if (rst_n && mreq && !was) begin
      if (wait_cnt < lat) begin
        wait_cnt++;
      end else begin
        item_t it;
        wait_cnt = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2/R3 unexpected transfer", {31'b0, mwe, maddr}, 64'h0);
        end else begin
          it = exp_q.pop_front();
          check(mwe == it.we && maddr == it.addr, it.tag, {31'b0, mwe, maddr},
                {31'b0, it.we, it.addr});
          if (it.we) check(mwdata == it.data, it.tag, mwdata, it.data);
        end
        mrdata = pat(maddr);
        if (maddr == err_addr) merr = 1'b1;
        else mack = 1'b1;
      end
    end
  end

  task automatic bus_wr(input logic [11:0] a, input bit s8, input logic [31:0] h,
                        input logic [31:0] l);
    req = 1'b1; we = 1'b1; size8 = s8; addr = a; wdh = h; wdl = l;
    #1;
    while (!ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input bit s8, output logic [63:0] d);
    req = 1'b1; we = 1'b0; size8 = s8; addr = a;
    #1;
    while (!ready) begin @(negedge clk); #1; end
    d = {rdh, rdl};
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (!ready && guard < 200) begin @(negedge clk); guard++; end
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog", 64'h0, 64'h1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [63:0] stg [4];
    logic [31:0] src, src2;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(ready == 1'b1 && mreq == 1'b0, "R1 idle after reset", {62'b0, ready, mreq}, 64'h2);
    bus_rd(12'hF00, 1'b1, d);
    check(d == 64'h0D00_0000, "R1 port reset value", d, 64'h0D00_0000);
    bus_rd(12'hA00, 1'b1, d);
    check(d == 64'h0, "R1 control reset", d, 64'h0);
    bus_rd(12'hE00, 1'b1, d);
    check(d == 64'h0, "R1 error reset", d, 64'h0);

    // R4 direct staging loads, R3 store, R11 high word ignored
    for (int i = 0; i < 4; i++) begin
      stg[i] = {32'h1111_0000 + 32'(i), 32'hC0DE_0000 + 32'(i)};
      bus_wr(12'(i * 8), 1'b1, stg[i][63:32], stg[i][31:0]);
    end
    for (int i = 0; i < 4; i++)
      push(1'b1, 32'h0000_1000 + 32'(i * 8), stg[i], "R4/R3/R11 store beat");
    bus_wr(12'h200, 1'b1, 32'hDEAD_BEEF, 32'h0000_1000);
    #1;
    check(ready == 1'b0, "R7 busy after trigger", {63'b0, ready}, 64'h0);
    wait_idle();
    #1;
    check(ready == 1'b1, "R7 ready after last ack", {63'b0, ready}, 64'h1);

    // R2 fetch with memory latency, then store to expose captured data
    lat = 2;
    src = 32'h2000_0040;
    for (int i = 0; i < 4; i++)
      push(1'b0, src + 32'(i * 8), 64'h0, "R2/R11 fetch beat");
    bus_wr(12'h100, 1'b1, 32'hFFFF_FFFF, src);
    wait_idle();
    lat = 0;
    for (int i = 0; i < 4; i++)
      push(1'b1, 32'h3000_0000 + 32'(i * 8), pat(src + 32'(i * 8)), "R2 fetched data");
    bus_wr(12'h200, 1'b1, 32'h0, 32'h3000_0000);
    wait_idle();

    // R5 control register
    bus_wr(12'hA00, 1'b1, 32'h1111_2222, 32'h3333_4444);
    bus_rd(12'hA00, 1'b1, d);
    check(d == 64'h1111_2222_3333_4444, "R5 control 8-byte", d, 64'h1111_2222_3333_4444);
    bus_wr(12'hA04, 1'b0, 32'h9999_9999, 32'h5555_6666);
    bus_rd(12'hA00, 1'b1, d);
    check(d == 64'h1111_2222_5555_6666, "R5 control low replace", d, 64'h1111_2222_5555_6666);
    bus_rd(12'hA04, 1'b0, d);
    check(d == 64'h0000_0000_5555_6666, "R5 control 4-byte read", d, 64'h5555_6666);

    // R9 port-address register
    bus_wr(12'hF00, 1'b1, 32'hAB00_0001, 32'h0F00_0000);
    bus_rd(12'hF00, 1'b1, d);
    check(d == 64'hAB00_0001_0F00_0000, "R9 port rw", d, 64'hAB00_0001_0F00_0000);

    // R10 wrong size / unmapped
    bus_wr(12'hA00, 1'b0, 32'h0, 32'h0);
    bus_rd(12'hA00, 1'b1, d);
    check(d == 64'h1111_2222_5555_6666, "R10 4-byte to A00 ignored", d, 64'h1111_2222_5555_6666);
    bus_rd(12'hA04, 1'b1, d);
    check(d == 64'h0, "R10 8-byte read A04", d, 64'h0);
    bus_rd(12'h300, 1'b1, d);
    check(d == 64'h0, "R10 unmapped read", d, 64'h0);
    bus_rd(12'h008, 1'b1, d);
    check(d == 64'h0, "R10 staging read", d, 64'h0);
    bus_wr(12'h100, 1'b0, 32'h0, 32'h5000_0000);
    #1;
    check(mreq == 1'b0 && ready == 1'b1, "R10 4-byte trigger ignored", {62'b0, mreq, ready}, 64'h1);
    @(negedge clk); #1;
    check(mreq == 1'b0, "R10 no late transfer", {63'b0, mreq}, 64'h0);
    bus_wr(12'h008, 1'b0, 32'h0, 32'hBAD0_BAD0);

    // R8 error aborts fetch on second beat
    src2 = 32'h0000_8000;
    err_addr = src2 + 32'd8;
    push(1'b0, src2, 64'h0, "R8 fetch beat 0");
    push(1'b0, src2 + 32'd8, 64'h0, "R8 fetch errored beat");
    bus_wr(12'h100, 1'b1, 32'h0, src2);
    wait_idle();
    err_addr = 32'hFFFF_FFF8;
    @(negedge clk); #1;
    check(mreq == 1'b0, "R8 burst aborted", {63'b0, mreq}, 64'h0);
    bus_rd(12'hE00, 1'b1, d);
    check(d == 64'h1, "R8 error bit set", d, 64'h1);
    push(1'b1, 32'h4000_0000, pat(src2), "R8 beat0 kept");
    for (int i = 1; i < 4; i++)
      push(1'b1, 32'h4000_0000 + 32'(i * 8), pat(src + 32'(i * 8)), "R8/R10 staging unchanged");
    bus_wr(12'h200, 1'b1, 32'h0, 32'h4000_0000);
    wait_idle();
    bus_wr(12'hE00, 1'b1, 32'h0, 32'h0);
    bus_rd(12'hE00, 1'b1, d);
    check(d == 64'h0, "R8 error write", d, 64'h0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2/R3 all transfers seen", 64'(exp_q.size()), 64'h0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule